// File: doc/BRIEF.md
# GPIO Interrupt Sense and Pending Unit

This block turns the already-synchronized inputs of a 32-pin general-purpose port into interrupt requests. Software picks a detection mode for each pin: rising edge, falling edge, both edges, high level or low level. It then turns detection on pin by pin. Each detection sets a per-pin pending latch. Software clears that latch by writing a one to it.

A separate unmask state decides which pending bits reach the interrupt outputs. Software sets it through one write-one register and clears it through another. The pins are split into a low half and a high half. Each half drives its own registered interrupt request. Software can read pending state in two ways: raw, one half per register, or combined with the unmask state.

The register interface is a plain single-cycle write port and a combinational read port, both addressed by word.

Top module: `gpio_irq_sense`

## Requirements
- R1: Pin n has a 4-bit mode field in mode register n/8 (word addresses 0 to 3), at bits 4*(n mod 8)+3 down to 4*(n mod 8). Mode registers read back what was written.
- R2: The mode codes behave as follows, where an edge means a change between two consecutive clock samples of the pin:
  - 8 detects a rising edge.
  - 9 detects a falling edge.
  - 10 detects a high level.
  - 11 detects a low level.
  - 12 detects either edge.
- R3: Any mode code other than 8 to 12 never sets the pin's pending bit.
- R4: The detection-enable register (address 4, read/write) gates detection. A pin whose enable bit is 0 cannot set its pending bit.
- R5: Writing the clear register (address 7) clears every pending bit whose data bit is 1 and leaves bits written as 0 unchanged.
- R6: Writing ones to address 5 unmasks those pins, and writing ones to address 6 masks them. Address 5 reads the current unmask state, and address 6 reads 0.
- R7: Address 10 reads pending AND unmask, so it reads 0 when no unmasked pin is pending.
- R8: Address 8 reads pending bits 15:0 and address 9 reads pending bits 31:16, both right-aligned with the upper 16 bits at 0.
- R9: `irq_lo` and `irq_hi` are each the registered OR of the unmasked pending bits of their half. Each follows its pending or unmask change one clock later.
- R10: When a clear and a new detection hit the same bit in the same cycle, the bit stays set. A level mode whose level is still active therefore keeps the bit set through a clear.
- R11: After reset all mode fields, detection enables, unmask bits and pending bits are 0, both interrupt outputs are low, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| irq_lo | output | 1 | Interrupt request, pins 15..0 |
| irq_hi | output | 1 | Interrupt request, pins 31..16 |

## Verification
The hardest case to reach from the ports is a clear write landing in the same clock as a fresh edge detection on the same pin. The stimulus produces it by presenting the clear write and the pin transition on the same falling edge, so that both are seen at a single rising edge.

Edge modes also need a known previous sample. The bench therefore parks each pin at its starting level while that pin's mode is zero. It then writes the mode and changes the pin immediately after that write's edge. One table walk covers every mode code against rising, falling and steady inputs, and places each case on a different pin across all four mode registers.

// File: rtl/gis_pkg.sv
package gis_pkg;
   localparam int REG_W   = 32;
   localparam int FIELD_W = 4;
   localparam int FLD_PER_REG = REG_W / FIELD_W;

   typedef enum logic [FIELD_W-1:0] {
      SENSE_RISE = 4'd8,
      SENSE_FALL = 4'd9,
      SENSE_HIGH = 4'd10,
      SENSE_LOW  = 4'd11,
      SENSE_BOTH = 4'd12
   } sense_e;

   // word addresses beyond the mode registers
   localparam logic [3:0] A_DETEN  = 4'd4;
   localparam logic [3:0] A_UNMASK = 4'd5;
   localparam logic [3:0] A_MASK   = 4'd6;
   localparam logic [3:0] A_CLEAR  = 4'd7;
   localparam logic [3:0] A_RAW_LO = 4'd8;
   localparam logic [3:0] A_RAW_HI = 4'd9;
   localparam logic [3:0] A_MASKED = 4'd10;
endpackage

// File: rtl/gis_cfg.sv
module gis_cfg
   import gis_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 4,
   localparam int MODE_REGS = NPINS / FLD_PER_REG
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [REG_W-1:0]           wr_data,
   output logic [NPINS*FIELD_W-1:0]   mode_flat,
   output logic [NPINS-1:0]           deten,
   output logic [NPINS-1:0]           unmask,
   output logic [NPINS-1:0]           clr_vec
);
   for (genvar r = 0; r < MODE_REGS; r++) begin : g_mode
      logic [REG_W-1:0] mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mode_q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(r))
            mode_q <= wr_data;
      end
      assign mode_flat[r*REG_W +: REG_W] = mode_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         deten  <= '0;
         unmask <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(A_DETEN))  deten  <= wr_data[NPINS-1:0];
         if (wr_addr == ADDR_W'(A_UNMASK)) unmask <= unmask | wr_data[NPINS-1:0];
         if (wr_addr == ADDR_W'(A_MASK))   unmask <= unmask & ~wr_data[NPINS-1:0];
      end
   end

   assign clr_vec = (wr_en && wr_addr == ADDR_W'(A_CLEAR)) ? wr_data[NPINS-1:0] : '0;
endmodule

// File: rtl/gis_detect.sv
module gis_detect
   import gis_pkg::*;
#(
   parameter int NPINS = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPINS-1:0]         pin_in,
   input  logic [NPINS*FIELD_W-1:0] mode_flat,
   input  logic [NPINS-1:0]         deten,
   output logic [NPINS-1:0]         hit
);
   logic [NPINS-1:0] pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= pin_in;
   end

   for (genvar n = 0; n < NPINS; n++) begin : g_pin
      logic [FIELD_W-1:0] fld;
      logic               raw;
      assign fld = mode_flat[n*FIELD_W +: FIELD_W];
      always_comb begin
         case (fld)
            SENSE_RISE: raw =  pin_in[n] & ~pin_q[n];
            SENSE_FALL: raw = ~pin_in[n] &  pin_q[n];
            SENSE_HIGH: raw =  pin_in[n];
            SENSE_LOW:  raw = ~pin_in[n];
            SENSE_BOTH: raw =  pin_in[n] ^  pin_q[n];
            default:    raw = 1'b0;
         endcase
      end
      assign hit[n] = raw & deten[n];
   end
endmodule

// File: rtl/gis_pend.sv
module gis_pend #(
   parameter int NPINS = 32,
   localparam int HALF = NPINS / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] hit,
   input  logic [NPINS-1:0] clr_vec,
   input  logic [NPINS-1:0] unmask,
   output logic [NPINS-1:0] pend,
   output logic [NPINS-1:0] masked,
   output logic             irq_lo,
   output logic             irq_hi
);
   assign masked = pend & unmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= '0;
         irq_lo <= 1'b0;
         irq_hi <= 1'b0;
      end else begin
         pend   <= (pend & ~clr_vec) | hit;
         irq_lo <= |masked[HALF-1:0];
         irq_hi <= |masked[NPINS-1:HALF];
      end
   end
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
   import gis_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 4,
   localparam int HALF      = NPINS / 2,
   localparam int MODE_REGS = NPINS / FLD_PER_REG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              irq_lo,
   output logic              irq_hi
);
   if (NPINS % 16 != 0 || NPINS < 16 || NPINS > 32) begin : g_bad_npins
      $error("NPINS must be 16 or 32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end

   logic [NPINS*FIELD_W-1:0] mode_flat;
   logic [NPINS-1:0] deten, unmask, clr_vec, hit, pend, masked;

   gis_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .mode_flat(mode_flat), .deten(deten),
      .unmask(unmask), .clr_vec(clr_vec)
   );

   gis_detect #(.NPINS(NPINS)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode_flat(mode_flat),
      .deten(deten), .hit(hit)
   );

   gis_pend #(.NPINS(NPINS)) u_pend (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr_vec(clr_vec),
      .unmask(unmask), .pend(pend), .masked(masked),
      .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   always_comb begin
      rd_data = '0;
      for (int r = 0; r < MODE_REGS; r++)
         if (rd_addr == ADDR_W'(r)) rd_data = mode_flat[r*REG_W +: REG_W];
      if (rd_addr == ADDR_W'(A_DETEN))  rd_data = REG_W'(deten);
      if (rd_addr == ADDR_W'(A_UNMASK)) rd_data = REG_W'(unmask);
      if (rd_addr == ADDR_W'(A_RAW_LO)) rd_data = REG_W'(pend[HALF-1:0]);
      if (rd_addr == ADDR_W'(A_RAW_HI)) rd_data = REG_W'(pend[NPINS-1:HALF]);
      if (rd_addr == ADDR_W'(A_MASKED)) rd_data = REG_W'(masked);
   end
endmodule

// File: rtl/gis_chk.sv
module gis_chk
   import gis_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 4,
   localparam int HALF = NPINS / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [REG_W-1:0]  wr_data,
   input logic [NPINS-1:0]  deten,
   input logic [NPINS-1:0]  unmask,
   input logic [NPINS-1:0]  hit,
   input logic [NPINS-1:0]  pend,
   input logic              irq_lo,
   input logic              irq_hi
);
   logic [NPINS-1:0] clr_seen;
   logic             mask_wr;
   assign clr_seen = (wr_en && wr_addr == ADDR_W'(A_CLEAR)) ? wr_data[NPINS-1:0] : '0;
   assign mask_wr  = wr_en && wr_addr == ADDR_W'(A_MASK);

   assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend) & ~$past(deten)) == '0));

   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & $past(clr_seen & ~hit)) == '0));

   assert_hit_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~pend & $past(hit)) == '0));

   assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> ((unmask & $past(wr_data[NPINS-1:0])) == '0));

   assert_irq_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_lo == $past(|(pend[HALF-1:0] & unmask[HALF-1:0]))));

   assert_irq_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_hi == $past(|(pend[NPINS-1:HALF] & unmask[NPINS-1:HALF]))));
endmodule

bind gpio_irq_sense gis_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_gis_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .deten(deten), .unmask(unmask), .hit(hit),
   .pend(pend), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/test_gpio_irq_sense.sv
module test_gpio_irq_sense;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_in = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq_lo, irq_hi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_sense i_gpio_irq_sense (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   // {mode, level before, level after, expected pending}
   localparam logic [6:0] VEC [15] = '{
      {4'd8,  1'b0, 1'b1, 1'b1}, {4'd8,  1'b1, 1'b0, 1'b0},
      {4'd8,  1'b1, 1'b1, 1'b0}, {4'd9,  1'b1, 1'b0, 1'b1},
      {4'd9,  1'b0, 1'b1, 1'b0}, {4'd10, 1'b0, 1'b1, 1'b1},
      {4'd10, 1'b1, 1'b0, 1'b0}, {4'd11, 1'b1, 1'b0, 1'b1},
      {4'd11, 1'b0, 1'b1, 1'b0}, {4'd12, 1'b0, 1'b1, 1'b1},
      {4'd12, 1'b1, 1'b0, 1'b1}, {4'd12, 1'b1, 1'b1, 1'b0},
      {4'd0,  1'b0, 1'b1, 1'b0}, {4'd13, 1'b0, 1'b1, 1'b0},
      {4'd7,  1'b1, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic next_cycle_sample();
      @(posedge clk);
      @(negedge clk);
   endtask

   logic [31:0] v;
   logic [3:0]  m;
   int          p;

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      for (int a = 0; a <= 10; a++) begin
         rd(4'(a), v);
         check("R11 reset register", v, 32'h0);
      end
      check("R11 reset irq_lo", {31'b0, irq_lo}, 32'h0);
      check("R11 reset irq_hi", {31'b0, irq_hi}, 32'h0);

      // R4 detection gate
      wr(4'd0, 32'd10 << 20);             // pin 5 high level
      @(negedge clk) pin_in = 32'h1 << 5;
      repeat (3) @(posedge clk);
      rd(4'd8, v);
      check("R4 disabled pin stays idle", v, 32'h0);
      wr(4'd4, 32'h1 << 5);
      rd(4'd4, v);
      check("R4 enable readback", v, 32'h1 << 5);
      @(posedge clk);
      rd(4'd8, v);
      check("R4 enabled pin pends", v, 32'h1 << 5);

      // R7 / R6 / R9 masking
      rd(4'd10, v);
      check("R7 masked status all masked", v, 32'h0);
      next_cycle_sample();
      check("R9 irq_lo low while masked", {31'b0, irq_lo}, 32'h0);
      wr(4'd5, 32'h1 << 5);
      rd(4'd5, v);
      check("R6 unmask readback", v, 32'h1 << 5);
      rd(4'd10, v);
      check("R7 masked status", v, 32'h1 << 5);
      next_cycle_sample();
      check("R9 irq_lo raised", {31'b0, irq_lo}, 32'h1);
      check("R9 irq_hi stays low", {31'b0, irq_hi}, 32'h0);
      wr(4'd6, 32'h1 << 5);
      rd(4'd6, v);
      check("R6 mask register reads 0", v, 32'h0);
      rd(4'd10, v);
      check("R6 mask clears masked status", v, 32'h0);
      next_cycle_sample();
      check("R9 irq_lo dropped after mask", {31'b0, irq_lo}, 32'h0);
      rd(4'd8, v);
      check("R8 raw keeps masked pending", v, 32'h1 << 5);

      // R10 level still active through clear
      wr(4'd7, 32'h1 << 5);
      rd(4'd8, v);
      check("R10 level survives clear", v, 32'h1 << 5);
      wr(4'd0, 32'h0);
      @(negedge clk) pin_in = '0;
      wr(4'd7, 32'h1 << 5);
      rd(4'd8, v);
      check("R5 clear after level removed", v, 32'h0);

      // R8 high half, R5 zero bits, R9 irq_hi
      wr(4'd4, 32'hFFFF_FFFF);
      wr(4'd5, 32'hFFFF_FFFF);
      wr(4'd2, 32'd8 << 16);              // pin 20 rising
      @(negedge clk) pin_in = 32'h1 << 20;
      @(posedge clk);
      rd(4'd9, v);
      check("R8 raw high half", v, 32'h1 << 4);
      rd(4'd8, v);
      check("R8 raw low half empty", v, 32'h0);
      next_cycle_sample();
      check("R9 irq_hi raised", {31'b0, irq_hi}, 32'h1);
      check("R9 irq_lo idle", {31'b0, irq_lo}, 32'h0);
      wr(4'd7, 32'hFFEF_FFFF);
      rd(4'd9, v);
      check("R5 zero bit leaves pending", v, 32'h1 << 4);
      wr(4'd7, 32'h1 << 20);
      rd(4'd9, v);
      check("R5 one bit clears pending", v, 32'h0);
      next_cycle_sample();
      check("R9 irq_hi dropped", {31'b0, irq_hi}, 32'h0);

      // R10 clear and rising edge in the same cycle
      @(negedge clk) pin_in = '0;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd7; wr_data = 32'h1 << 20;
      pin_in = 32'h1 << 20;
      @(posedge clk);
      #1 wr_en = 1'b0;
      rd(4'd9, v);
      check("R10 detection beats clear", v, 32'h1 << 4);
      wr(4'd2, 32'h0);
      @(negedge clk) pin_in = '0;
      wr(4'd7, 32'hFFFF_FFFF);

      // R1 R2 R3 mode table walk
      for (int i = 0; i < 15; i++) begin
         m = VEC[i][6:3];
         p = 2 * i;
         @(negedge clk) pin_in = 32'(VEC[i][2]) << p;
         @(posedge clk);
         wr(4'd7, 32'hFFFF_FFFF);
         wr(4'(p / 8), 32'(m) << (4 * (p % 8)));
         pin_in = 32'(VEC[i][1]) << p;
         @(posedge clk);
         rd(4'(p / 8), v);
         check("R1 mode field placement", v, 32'(m) << (4 * (p % 8)));
         rd((p < 16) ? 4'd8 : 4'd9, v);
         if (m >= 4'd8 && m <= 4'd12)
            check("R2 mode detection", v, 32'(VEC[i][0]) << (p % 16));
         else
            check("R3 unused code ignored", v, 32'(VEC[i][0]) << (p % 16));
         wr(4'(p / 8), 32'h0);
         @(negedge clk) pin_in = '0;
         wr(4'd7, 32'hFFFF_FFFF);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule